// File: doc/BRIEF.md
# Bus Protection and Timeout Monitor

This block sits beside a simple system bus and watches each bus cycle for trouble. A handful of detectors elsewhere on the chip report error conditions:

- two address regions claiming the same access
- a write into a read-only region
- a touch on a clock-gated peripheral
- a peripheral transfer error
- a read-protect hit
- an external error
- a privilege (supervisor/user) mismatch

The monitor records each of these in a sticky flag. A programmable watchdog adds one more source: a bus cycle that runs too long.

Each flag has an enable bit beside it. When an error arrives during a cycle and its enable is set, the monitor pulses an access-error termination that ends the cycle. With the enable clear, the event is only recorded. Software reads the flags and clears them by writing ones. A second small register holds the watchdog length code and a bus-lock bit that tells the arbiter to leave ownership with the current master.

Top module: `bus_guard`

## Requirements
- R1: After reset, register 0 reads 0x000B: flags all 0, and the enable byte has the timeout, external and privilege enables set. Register 1 reads 0x0000, accessErr is 0 and busLock is 0.
- R2: Register 0 holds the flags in bits 15..8 and the enables in bits 7..0. Bit n+8 and bit n pair up. From n=7 down to n=0 the sources are: region conflict (errSrc[6]), write protect (errSrc[5]), gated module (errSrc[4]), peripheral error (errSrc[3]), watchdog timeout (internal), read protect (errSrc[2]), external (errSrc[1]) and privilege (errSrc[0]).
- R3: A flag stays set until register 0 is written with a 1 in that flag's position. Writing 0 leaves it unchanged. If an error sets a flag on the same clock that a write clears it, the flag stays set.
- R4: Writing register 0 loads bits 7..0 into the enables, and they read back as written.
- R5: When an error is sampled during a cycle and its enable is 1, accessErr is high for exactly one clock, on the clock after the error is sampled, and the cycle ends. With the enable at 0, only the flag is set.
- R6: Error inputs are ignored when no bus cycle is open. A cycle opens on cycStart and closes on cycAck or on a termination.
- R7: Register 1 bits 2..0 select a watchdog length of 128 << code clocks. With the timeout enable (bit 3 of register 0) set, accessErr goes high that many clocks after cycStart is sampled, and flag bit 11 sets. A cycAck before then stops the count.
- R8: With the timeout enable at 0, an open cycle never times out.
- R9: Several errors sampled on the same clock all set their flags. They give a single one-clock termination when any of them is enabled.
- R10: Register 1 bit 3 is the bus-lock bit, and the busLock output follows it.
- R11: regAddr 0 selects the protection register and regAddr 1 the control register. Register 1 reads as {12'b0, lock, code}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 protection, 1 control |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for regAddr (combinational) |
| cycStart | input | 1 | Start of a bus cycle |
| cycAck | input | 1 | Normal acknowledge ending the cycle |
| errSrc | input | 7 | Error detector inputs, order as in R2 |
| accessErr | output | 1 | One-clock access-error termination |
| busLock | output | 1 | Keep bus ownership with the current master |

## Verification
The hardest cases to reach are the clock boundaries. One is the watchdog firing on exactly the clock its reference names. Another is an error that sets a flag on the same clock software clears it. The bench starts cycles with several length codes and checks accessErr one clock before and on the expected clock. It also lines up a clearing write with an error pulse in the same clock. Random enable patterns and error vectors, some arriving with no cycle open, cover masking and multi-error merging against a bench model.

// File: rtl/bus_guard_pkg.sv
package bus_guard_pkg;
  localparam logic [7:0] EN_RESET = 8'h0B;
  localparam int TIMEOUT_BIT = 3;

  typedef struct packed {
    logic wrProt;
    logic wrCtrl;
    logic wdHit;
  } guard_strobe_t;
endpackage

// File: rtl/bus_guard_ctrl.sv
module bus_guard_ctrl
  import bus_guard_pkg::*;
#(
  parameter int BASE_LOG2 = 7,
  parameter int REF_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic             cycStart,
  input  logic             cycAck,
  input  logic             abortNow,
  input  logic             wdEn,
  input  logic [REF_W-1:0] wdRef,
  output logic             busy,
  output guard_strobe_t    strobe
);
  localparam int CODES = 1 << REF_W;
  localparam int CNT_W = BASE_LOG2 + CODES;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(1) << (BASE_LOG2 + int'(wdRef));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (cycStart) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy && (cycAck || abortNow)) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    strobe.wrProt = regWrEn && (regAddr == 1'b0);
    strobe.wrCtrl = regWrEn && (regAddr == 1'b1);
    strobe.wdHit  = busy && wdEn && !cycAck && (cnt == limit - 1'b1);
  end
endmodule

// File: rtl/bus_guard_dp.sv
module bus_guard_dp
  import bus_guard_pkg::*;
#(
  parameter int REF_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  guard_strobe_t    strobe,
  input  logic             busy,
  input  logic             regAddr,
  input  logic [15:0]      regWrData,
  input  logic [6:0]       errSrc,
  output logic [15:0]      regRdData,
  output logic             abortNow,
  output logic             accessErr,
  output logic             busLock,
  output logic             wdEn,
  output logic [REF_W-1:0] wdRef,
  output logic [7:0]       statusBits,
  output logic [7:0]       enableBits
);
  logic [7:0] evt;
  logic [7:0] clrMask;

  assign evt      = busy ? {errSrc[6:3], strobe.wdHit, errSrc[2:0]} : 8'h00;
  assign clrMask  = strobe.wrProt ? regWrData[15:8] : 8'h00;
  assign abortNow = |(evt & enableBits);
  assign wdEn     = enableBits[TIMEOUT_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusBits <= 8'h00;
      enableBits <= EN_RESET;
      busLock    <= 1'b0;
      wdRef      <= '0;
      accessErr  <= 1'b0;
    end else begin
      statusBits <= (statusBits & ~clrMask) | evt;
      accessErr  <= abortNow;
      if (strobe.wrProt) enableBits <= regWrData[7:0];
      if (strobe.wrCtrl) begin
        busLock <= regWrData[REF_W];
        wdRef   <= regWrData[REF_W-1:0];
      end
    end
  end

  always_comb begin
    if (regAddr) regRdData = {{(15 - REF_W){1'b0}}, busLock, wdRef};
    else         regRdData = {statusBits, enableBits};
  end
endmodule

// File: rtl/bus_guard.sv
module bus_guard
  import bus_guard_pkg::*;
#(
  parameter int BASE_LOG2 = 7,
  parameter int REF_W = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regAddr,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  input  logic        cycStart,
  input  logic        cycAck,
  input  logic [6:0]  errSrc,
  output logic        accessErr,
  output logic        busLock
);
  guard_strobe_t    strobe;
  logic             busy;
  logic             abortNow;
  logic             wdEn;
  logic [REF_W-1:0] wdRef;
  logic [7:0]       statusBits;
  logic [7:0]       enableBits;

  bus_guard_ctrl #(.BASE_LOG2(BASE_LOG2), .REF_W(REF_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .cycStart(cycStart), .cycAck(cycAck), .abortNow(abortNow),
    .wdEn(wdEn), .wdRef(wdRef), .busy(busy), .strobe(strobe)
  );

  bus_guard_dp #(.REF_W(REF_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy),
    .regAddr(regAddr), .regWrData(regWrData), .errSrc(errSrc),
    .regRdData(regRdData), .abortNow(abortNow), .accessErr(accessErr),
    .busLock(busLock), .wdEn(wdEn), .wdRef(wdRef),
    .statusBits(statusBits), .enableBits(enableBits)
  );
endmodule

// File: rtl/bus_guard_chk.sv
module bus_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic [7:0] statusBits,
  input logic [7:0] enableBits,
  input logic       regWrEn,
  input logic       regAddr,
  input logic       cycStart,
  input logic       accessErr
);
  p_abort_needs_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |-> $past(busy));

  p_abort_ends_cycle_r5: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |-> (!busy || $past(cycStart)));

  p_abort_has_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |-> ((statusBits & $past(enableBits)) != 8'h00));

  p_sticky_flags_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regWrEn && !regAddr) |-> ((statusBits & $past(statusBits)) == $past(statusBits)));

  p_timeout_in_cycle_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusBits[3]) |-> $past(busy && enableBits[3]));
endmodule

bind bus_guard bus_guard_chk uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .statusBits(statusBits),
  .enableBits(enableBits), .regWrEn(regWrEn), .regAddr(regAddr),
  .cycStart(cycStart), .accessErr(accessErr)
);

// File: tb/bus_guard_test.sv
module bus_guard_test;
  logic clk = 1'b0;
  logic rstN, regWrEn, regAddr, cycStart, cycAck, accessErr, busLock;
  logic [15:0] regWrData, regRdData;
  logic [6:0] errSrc;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  bus_guard uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cycStart(cycStart),
    .cycAck(cycAck), .errSrc(errSrc), .accessErr(accessErr), .busLock(busLock)
  );

  function automatic logic [7:0] expFlags(input logic [6:0] v, input logic hit);
    return {v[6:3], hit, v[2:0]};
  endfunction

  function automatic logic expAbort(input logic [7:0] flags, input logic [7:0] en);
    return |(flags & en);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readReg(input logic a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic writeReg(input logic a, input logic [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic startCycle();
    cycStart = 1'b1;
    @(negedge clk);
    cycStart = 1'b0;
  endtask

  task automatic ackCycle();
    cycAck = 1'b1;
    @(negedge clk);
    cycAck = 1'b0;
  endtask

  task automatic fireErr(input logic [6:0] v, input string tag, input logic abortExp);
    errSrc = v;
    @(negedge clk);
    check(tag, {15'd0, accessErr}, {15'd0, abortExp});
    errSrc = '0;
    @(negedge clk);
    check({tag, " single pulse"}, {15'd0, accessErr}, 16'd0);
  endtask

  task automatic timeoutRun(input logic [2:0] code);
    int len;
    logic early;
    logic [15:0] d;
    len = 128 << code;
    early = 1'b0;
    writeReg(1'b1, {13'd0, code});
    writeReg(1'b0, 16'hFF08);
    startCycle();
    for (int i = 0; i < len - 1; i++) begin
      early = early | accessErr;
      @(negedge clk);
    end
    early = early | accessErr;
    check("R7 no early timeout", {15'd0, early}, 16'd0);
    @(negedge clk);
    check("R7 timeout on exact clock", {15'd0, accessErr}, 16'd1);
    readReg(1'b0, d);
    check("R7 timeout flag bit 11", d, 16'h0808);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic seen;
    void'($urandom(32'd4711));
    rstN = 1'b0; regWrEn = 1'b0; regAddr = 1'b0; regWrData = '0;
    cycStart = 1'b0; cycAck = 1'b0; errSrc = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readReg(1'b0, d); check("R1 protection reset", d, 16'h000B);
    readReg(1'b1, d); check("R1 control reset", d, 16'h0000);
    check("R1 accessErr reset", {15'd0, accessErr}, 16'd0);
    check("R1 busLock reset", {15'd0, busLock}, 16'd0);

    // R10 / R11 control register
    writeReg(1'b1, 16'hFFFD);
    readReg(1'b1, d); check("R11 control readback", d, 16'h000D);
    check("R10 busLock set", {15'd0, busLock}, 16'd1);
    readReg(1'b0, d); check("R11 protection untouched", d, 16'h000B);
    writeReg(1'b1, 16'h0000);
    check("R10 busLock clear", {15'd0, busLock}, 16'd0);

    // R4 enables
    writeReg(1'b0, 16'h00F0);
    readReg(1'b0, d); check("R4 enable readback", d, 16'h00F0);

    // R6 no cycle open
    writeReg(1'b0, 16'h00FF);
    fireErr(7'h7F, "R6 idle no abort", 1'b0);
    readReg(1'b0, d); check("R6 idle no flags", d, 16'h00FF);

    // R5 disabled: flag only; R3 W1C
    writeReg(1'b0, 16'h0000);
    startCycle();
    fireErr(7'b1000000, "R5 disabled no abort", 1'b0);
    readReg(1'b0, d); check("R5 flag recorded", d, 16'h8000);
    writeReg(1'b0, 16'h0000);
    readReg(1'b0, d); check("R3 write 0 keeps flag", d, 16'h8000);
    writeReg(1'b0, 16'h8000);
    readReg(1'b0, d); check("R3 write 1 clears flag", d, 16'h0000);

    // R3 set wins over clear
    writeReg(1'b0, 16'h0000);
    fireErr(7'b1000000, "R3 setup", 1'b0);
    regWrEn = 1'b1; regAddr = 1'b0; regWrData = 16'h8000; errSrc = 7'b1000000;
    @(negedge clk);
    regWrEn = 1'b0; errSrc = '0;
    readReg(1'b0, d); check("R3 set beats clear", d, 16'h8000);
    ackCycle();

    // R2 / R5 each source enabled
    for (int i = 0; i < 7; i++) begin
      writeReg(1'b0, 16'hFFF7);
      startCycle();
      fireErr(7'(1 << i), "R5 enabled abort", 1'b1);
      readReg(1'b0, d);
      check("R2 flag position", d, {expFlags(7'(1 << i), 1'b0), 8'hF7});
    end

    // R9 several errors at once
    writeReg(1'b0, 16'hFF02);
    startCycle();
    fireErr(7'b1000011, "R9 one abort", 1'b1);
    readReg(1'b0, d); check("R9 all flags set", d, 16'h8302);

    // R7 watchdog
    timeoutRun(3'd0);
    timeoutRun(3'd1);
    timeoutRun(3'd2);
    writeReg(1'b1, 16'h0000);
    writeReg(1'b0, 16'hFF08);
    startCycle();
    repeat (100) @(negedge clk);
    ackCycle();
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin seen = seen | accessErr; @(negedge clk); end
    check("R7 ack stops watchdog", {15'd0, seen}, 16'd0);
    readReg(1'b0, d); check("R7 no flag after ack", d, 16'h0008);

    // R8 watchdog disabled
    writeReg(1'b0, 16'hFF00);
    startCycle();
    seen = 1'b0;
    for (int i = 0; i < 300; i++) begin seen = seen | accessErr; @(negedge clk); end
    check("R8 no timeout when disabled", {15'd0, seen}, 16'd0);
    readReg(1'b0, d); check("R8 no flag when disabled", d, 16'h0000);
    ackCycle();

    // Random: R5 / R6 / R9 against the model
    for (int k = 0; k < 150; k++) begin
      logic [7:0] en;
      logic [6:0] v;
      logic open;
      en = 8'($urandom) & 8'hF7;
      v = 7'($urandom);
      open = ($urandom % 4) != 0;
      writeReg(1'b0, {8'hFF, en});
      if (open) startCycle();
      fireErr(v, "R5 random abort", open && expAbort(expFlags(v, 1'b0), en));
      readReg(1'b0, d);
      check("R9 random flags", d, {open ? expFlags(v, 1'b0) : 8'h00, en});
      ackCycle();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule